// File: doc/BRIEF.md
# Self-Stopping Binary Counter

This block counts clock edges in a small binary register and halts on its own once it reaches a terminal value. It does not wrap around. When counting up, the terminal value is a programmable stop value. When counting down, the terminal value is zero.

The halt comes from gating the count enable inside a fully synchronous register. The register is never reset to stop it. This models a ripple counter whose first stage is forced from toggle into hold.

A synchronous clear starts a new run. In up mode it loads zero, and in down mode it loads the all-ones maximum. The stop value can be changed while the counter is halted. Counting then resumes only if the new value lies ahead of the current count.

Top module: `ssc_top`

## Requirements
- R1: With `clr` high and `dir_down` low at a clock edge, `count` becomes 0 after that edge, whatever its previous value or halt state.
- R2: With `clr` high and `dir_down` high at a clock edge, `count` becomes the all-ones value (15 for WIDTH=4) after that edge.
- R3: In up mode (`dir_down`=0) with `clr` low and `count` below `stop_val`, each clock edge raises `count` by exactly one.
- R4: In up mode, once `count` equals `stop_val` the count stays unchanged on later edges and `stopped` is 1.
- R5: In down mode (`dir_down`=1) with `clr` low, a nonzero `count` drops by exactly one per edge. At zero it holds at zero with `stopped` at 1.
- R6: `stopped` is 1 exactly when `count` equals the active terminal value: `stop_val` in up mode, 0 in down mode.
- R7: In up mode, raising `stop_val` above a halted count resumes counting on the next edge, up to the new value.
- R8: In up mode, a `stop_val` below the current count leaves the count frozen (no wrap) with `stopped` at 0.
- R9: In up mode with `stop_val`=0, the count stays at 0 after a clear and `stopped` is 1.
- R10: With `stop_val` equal to the all-ones value, the up count reaches that value and holds without wrapping to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, loads the start value of the selected direction |
| dir_down | input | 1 | 0 = count up toward `stop_val`, 1 = count down toward 0 |
| stop_val | input | WIDTH | Programmed terminal value for up mode |
| count | output | WIDTH | Current count |
| stopped | output | 1 | High while the count sits at the active terminal value |

## Verification
The bench drives the counter into the halt state in both directions and holds it there for many cycles. A design that gated the enable wrongly would creep past the stop value or wrap from 15 to 0 or from 0 to 15.

It moves `stop_val` above, onto and below a halted count. A design using an equality-only enable would wrap all the way round when the stop value falls behind the count. A design that ignored the new value would never resume.

Edge stop values of 0 and 15 are covered, as is a clear issued in mid-halt. These catch off-by-one terminal comparisons and a clear that fails to release the halt.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ssc_dir_e;
endpackage

// File: rtl/ssc_enable.sv
module ssc_enable #(
  parameter int WIDTH = 4
) (
  input  logic             dir_down,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] stop_val,
  output logic             adv_up,
  output logic             adv_down,
  output logic             at_term
);
  import ssc_pkg::*;

  function automatic logic ahead_up(input logic [WIDTH-1:0] c, input logic [WIDTH-1:0] lim);
    return c < lim;
  endfunction

  function automatic logic nonzero(input logic [WIDTH-1:0] c);
    return |c;
  endfunction

  ssc_dir_e dir;
  assign dir = ssc_dir_e'(dir_down);

  always_comb begin
    adv_up   = 1'b0;
    adv_down = 1'b0;
    at_term  = 1'b0;
    if (dir == DIR_UP) begin
      adv_up  = ahead_up(cur, stop_val);
      at_term = (cur == stop_val);
    end else begin
      adv_down = nonzero(cur);
      at_term  = !nonzero(cur);
    end
  end
endmodule

// File: rtl/ssc_state.sv
module ssc_state #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             dir_down,
  input  logic             adv_up,
  input  logic             adv_down,
  output logic [WIDTH-1:0] cur
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  function automatic logic [WIDTH-1:0] start_value(input logic down);
    return down ? ALL_ONES : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (clr)
      cur <= start_value(dir_down);
    else if (adv_up)
      cur <= cur + ONE;
    else if (adv_down)
      cur <= cur - ONE;
  end
endmodule

// File: rtl/ssc_top.sv
module ssc_top #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             dir_down,
  input  logic [WIDTH-1:0] stop_val,
  output logic [WIDTH-1:0] count,
  output logic             stopped
);
  logic             adv_up;
  logic             adv_down;
  logic             at_term;
  logic [WIDTH-1:0] cur;

  ssc_enable #(.WIDTH(WIDTH)) u_enable (
    .dir_down (dir_down),
    .cur      (cur),
    .stop_val (stop_val),
    .adv_up   (adv_up),
    .adv_down (adv_down),
    .at_term  (at_term)
  );

  ssc_state #(.WIDTH(WIDTH)) u_state (
    .clk      (clk),
    .clr      (clr),
    .dir_down (dir_down),
    .adv_up   (adv_up),
    .adv_down (adv_down),
    .cur      (cur)
  );

  assign count   = cur;
  assign stopped = at_term;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic             dir_down,
  input logic [WIDTH-1:0] stop_val,
  input logic [WIDTH-1:0] count,
  input logic             stopped,
  input logic             adv_up,
  input logic             adv_down
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  p_clear_up_r1: assert property (@(posedge clk) disable iff (!armed)
    (clr && !dir_down) |=> (count == '0));

  p_clear_down_r2: assert property (@(posedge clk) disable iff (!armed)
    (clr && dir_down) |=> (count == ALL_ONES));

  p_step_up_r3: assert property (@(posedge clk) disable iff (clr || !armed)
    adv_up |=> (count == $past(count) + WIDTH'(1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (clr || !armed)
    stopped |=> $stable(count));

  p_step_down_r5: assert property (@(posedge clk) disable iff (clr || !armed)
    adv_down |=> (count == $past(count) - WIDTH'(1)));

  p_one_dir_r6: assert property (@(posedge clk) disable iff (!armed)
    !(adv_up && adv_down) && !(stopped && (adv_up || adv_down)));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (clr || !armed)
    (!dir_down && (count > stop_val)) |=> $stable(count));
endmodule

bind ssc_top ssc_checker #(.WIDTH(WIDTH)) u_ssc_checker (
  .clk      (clk),
  .clr      (clr),
  .dir_down (dir_down),
  .stop_val (stop_val),
  .count    (count),
  .stopped  (stopped),
  .adv_up   (adv_up),
  .adv_down (adv_down)
);

// File: tb/tb_ssc_top.sv
module tb_ssc_top;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         clr = 1'b0;
  logic         dir_down = 1'b0;
  logic [W-1:0] stop_val = '0;
  logic [W-1:0] count;
  logic         stopped;

  int n_tests = 0;
  int n_fail  = 0;
  int model   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ssc_top #(.WIDTH(W)) dut (
    .clk(clk), .clr(clr), .dir_down(dir_down), .stop_val(stop_val),
    .count(count), .stopped(stopped)
  );

  task automatic check(input string tag, input int exp_cnt, input bit exp_stp);
    n_tests++;
    if (int'(count) != exp_cnt || stopped !== exp_stp) begin
      n_fail++;
      $display("FAIL %s: count=%0d stopped=%0b expected count=%0d stopped=%0b",
               tag, count, stopped, exp_cnt, exp_stp);
    end
  endtask

  // One clock: inputs already set at negedge; model follows the requirements.
  task automatic step(input string tag);
    @(posedge clk);
    if (clr) model = dir_down ? MAX : 0;
    else if (dir_down) begin
      if (model > 0) model = model - 1;
    end else if (model < int'(stop_val)) model = model + 1;
    @(negedge clk);
    check(tag, model, dir_down ? (model == 0) : (model == int'(stop_val)));
  endtask

  task automatic set_in(input bit c, input bit d, input int s);
    clr = c; dir_down = d; stop_val = W'(s);
  endtask

  initial begin
    @(negedge clk);
    // R1: clear in up mode
    set_in(1, 0, 10); step("R1");
    set_in(0, 0, 10);
    // R3 then R4: count to 10 and hold
    for (int i = 0; i < 10; i++) step("R3");
    for (int i = 0; i < 5; i++) step("R4");
    // R7: raise stop value while halted
    set_in(0, 0, 13);
    for (int i = 0; i < 5; i++) step("R7");
    // R8: stop value below count, frozen with flag low
    set_in(0, 0, 4);
    for (int i = 0; i < 4; i++) step("R8");
    // R6: stop value set onto the current count
    set_in(0, 0, 13);
    step("R6");
    // R1: clear from a halted state releases it
    set_in(1, 0, 13); step("R1");
    set_in(0, 0, 13); step("R6");
    // R2: clear in down mode
    set_in(1, 1, 3); step("R2");
    set_in(0, 1, 3);
    // R5: count to zero and hold
    for (int i = 0; i < 15; i++) step("R5");
    for (int i = 0; i < 4; i++) step("R5");
    // R9: stop value zero
    set_in(1, 0, 0); step("R9");
    set_in(0, 0, 0);
    for (int i = 0; i < 3; i++) step("R9");
    // R10: stop at all ones, no wrap
    set_in(0, 0, MAX);
    for (int i = 0; i < 15; i++) step("R10");
    for (int i = 0; i < 4; i++) step("R10");
    // R6: direction flip mid-run, flag follows terminal of new direction
    set_in(0, 1, MAX);
    for (int i = 0; i < 6; i++) step("R6");
    set_in(0, 0, 12);
    for (int i = 0; i < 5; i++) step("R6");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule